// File: doc/BRIEF.md
# Grayscale LED PWM Array with Slot Brightness

This block turns a per-channel 9-bit intensity into an "LED on" enable for a large array of LED channels. All channels share one time base, which runs on a separate PWM reference clock. A 9-bit slot counter steps through a grayscale frame of 511 unit slots. A channel is lit in the first L slots of every frame, where L is its intensity. Zero is never lit and 0x1FF is lit in every slot.

Each unit slot is split into reference clocks, and a global 3-bit brightness code blanks the tail of every slot. With the mode select at 0, a slot is 8 clocks long and lit for (code+1) of them. With the mode select at 1, a slot is 16 clocks long and lit for (code+9) of them. The lit part always sits at the start of the slot. An active-low output enable forces every channel off.

The intensities come from a register bank outside this block, packed into one flat vector. The enables feed the output drivers. The block is synchronous to the PWM reference clock and has an active-high synchronous reset.

Top module: `gray_pwm_array`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `led_on` is 0 after that edge, and both counters return to slot 0, clock 0.
- R2: Over any full frame, a channel with intensity L (0..511) is lit in exactly L of the 511 slots. Intensity 0 is never lit.
- R3: With `bright_mode` = 0, a slot lasts 8 clocks and a lit slot drives the channel high for the first (`bright_code`+1) of them.
- R4: With `bright_mode` = 1, a slot lasts 16 clocks and a lit slot drives the channel high for the first (`bright_code`+9) of them.
- R5: With `out_en_n` high at a clock edge, every bit of `led_on` is 0 after that edge, whatever the intensities are.
- R6: `led_on` is registered. After reset is released, the first edge shows slot 0, clock 0. Slot k begins on the edge (k × slot length) + 1 after release.
- R7: Channel i takes its intensity from `level_flat[9i+8:9i]` and drives `led_on[i]`. Channels do not affect one another.
- R8: With intensity 0x1FF, mode 0 and code 7, the channel stays high on every clock.
- R9: A change of mode or code takes effect without a reset. If the clock-within-slot count is at or past the end of the new slot, it wraps to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM reference clock |
| rst | input | 1 | Synchronous reset, active high |
| out_en_n | input | 1 | Output enable, active low; high forces all channels off |
| bright_mode | input | 1 | Slot length select: 0 = 8 clocks, 1 = 16 clocks |
| bright_code | input | 3 | Brightness code; sets the lit clocks in each slot |
| level_flat | input | CH*9 | Packed 9-bit intensities, channel i at bits [9i+8:9i] |
| led_on | output | CH | Per-channel LED-on enable |

## Verification
Every result shows up one edge after the counter state or input that causes it, because `led_on` is registered. The bench sets inputs on the falling edge and samples shortly after the next rising edge. The cycle-exact test counts edges from the release of reset: slot 0, clock 0 appears on edge 1, and slot 1 starts on edge 9 in mode 0. The intensity tests do not depend on phase. After each change of inputs the bench waits 20 clocks, then counts the high samples of each channel over exactly one frame length (4088 or 8176 clocks). It compares that count with intensity times lit clocks per slot, so the counters' phase does not need to be known.

// File: rtl/gray_pwm_pkg.sv
package gray_pwm_pkg;
    localparam int LVL_W     = 9;
    localparam int SLOTS     = 511;
    localparam int SUB_W     = 4;
    localparam int CODE_W    = 3;
    localparam int ONCNT_W   = SUB_W + 1;

    typedef enum logic {
        SLOT_OF_8  = 1'b0,
        SLOT_OF_16 = 1'b1
    } slot_mode_e;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        level_t           slot;
    } tbase_t;

    function automatic logic [SUB_W-1:0] last_sub(slot_mode_e m);
        return (m == SLOT_OF_16) ? SUB_W'(15) : SUB_W'(7);
    endfunction

    function automatic logic [ONCNT_W-1:0] lit_clocks(slot_mode_e m, logic [CODE_W-1:0] code);
        logic [ONCNT_W-1:0] base;
        base = (m == SLOT_OF_16) ? ONCNT_W'(9) : ONCNT_W'(1);
        return base + ONCNT_W'(code);
    endfunction
endpackage

// File: rtl/gray_pwm_timebase.sv
module gray_pwm_timebase
    import gray_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SUB_W-1:0] sub_last,
    output tbase_t           tb
);
    localparam level_t SLOT_END = level_t'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tb <= '0;
        end else if (tb.sub >= sub_last) begin
            tb.sub  <= '0;
            tb.slot <= (tb.slot == SLOT_END) ? '0 : tb.slot + level_t'(1);
        end else begin
            tb.sub <= tb.sub + SUB_W'(1);
        end
    end
endmodule

// File: rtl/gray_pwm_window.sv
module gray_pwm_window
    import gray_pwm_pkg::*;
(
    input  slot_mode_e        mode,
    input  logic [CODE_W-1:0] code,
    input  logic [SUB_W-1:0]  sub,
    input  logic              out_en_n,
    output logic              lit
);
    logic [ONCNT_W-1:0] span;

    always_comb begin
        span = lit_clocks(mode, code);
        lit  = !out_en_n && ({1'b0, sub} < span);
    end
endmodule

// File: rtl/gray_pwm_lane.sv
module gray_pwm_lane
    import gray_pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lit,
    input  level_t slot,
    input  level_t level,
    output logic   on
);
    always_ff @(posedge clk) begin
        if (rst) on <= 1'b0;
        else     on <= lit && (slot < level);
    end
endmodule

// File: rtl/gray_pwm_array.sv
module gray_pwm_array
    import gray_pwm_pkg::*;
#(
    parameter int CH = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                out_en_n,
    input  logic                bright_mode,
    input  logic [CODE_W-1:0]   bright_code,
    input  logic [CH*LVL_W-1:0] level_flat,
    output logic [CH-1:0]       led_on
);
    slot_mode_e       mode;
    logic [SUB_W-1:0] sub_last;
    tbase_t           tb;
    logic             lit;

    assign mode     = slot_mode_e'(bright_mode);
    assign sub_last = last_sub(mode);

    gray_pwm_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .sub_last (sub_last),
        .tb       (tb)
    );

    gray_pwm_window u_win (
        .mode     (mode),
        .code     (bright_code),
        .sub      (tb.sub),
        .out_en_n (out_en_n),
        .lit      (lit)
    );

    for (genvar i = 0; i < CH; i++) begin : g_lane
        gray_pwm_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .lit   (lit),
            .slot  (tb.slot),
            .level (level_flat[i*LVL_W +: LVL_W]),
            .on    (led_on[i])
        );
    end
endmodule

// File: rtl/gray_pwm_checker.sv
module gray_pwm_checker
    import gray_pwm_pkg::*;
#(
    parameter int CH = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             out_en_n,
    input level_t           level_lo,
    input logic [CH-1:0]    led_on,
    input logic [SUB_W-1:0] sub_cnt,
    input level_t           slot_cnt,
    input logic [SUB_W-1:0] sub_last
);
    AST_RESET_DARK: assert property (@(posedge clk)
        $past(rst) |-> led_on == '0); // R1

    AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (rst)
        ($past(out_en_n) && !$past(rst)) |-> led_on == '0); // R5

    AST_ZERO_LEVEL_DARK: assert property (@(posedge clk) disable iff (rst)
        ($past(level_lo) == '0 && !$past(rst)) |-> !led_on[0]); // R2

    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        slot_cnt < level_t'(SLOTS)); // R2

    AST_SUB_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(sub_last)) |-> sub_cnt <= sub_last); // R9

    AST_SLOT_HOLDS_MIDSLOT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sub_cnt) < $past(sub_last)) |-> $stable(slot_cnt)); // R3
endmodule

bind gray_pwm_array gray_pwm_checker #(.CH(CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .out_en_n (out_en_n),
    .level_lo (level_flat[8:0]),
    .led_on   (led_on),
    .sub_cnt  (tb.sub),
    .slot_cnt (tb.slot),
    .sub_last (sub_last)
);

// File: tb/tb_gray_pwm_array.sv
`timescale 1ns/1ps
module tb_gray_pwm_array;
    localparam int CH = 48;
    localparam int NV = 6;
    // vector: [15] out_en_n, [14] mode, [13:11] code, [8:0] seed
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd7, 2'b00, 9'd37},
        {1'b0, 1'b0, 3'd0, 2'b00, 9'd101},
        {1'b0, 1'b1, 3'd7, 2'b00, 9'd5},
        {1'b0, 1'b1, 3'd0, 2'b00, 9'd211},
        {1'b0, 1'b0, 3'd3, 2'b00, 9'd77},
        {1'b1, 1'b1, 3'd5, 2'b00, 9'd19}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              out_en_n = 1'b0;
    logic              bright_mode = 1'b0;
    logic [2:0]        bright_code = 3'd0;
    logic [CH*9-1:0]   level_flat = '0;
    logic [CH-1:0]     led_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gray_pwm_array #(.CH(CH)) dut (
        .clk         (clk),
        .rst         (rst),
        .out_en_n    (out_en_n),
        .bright_mode (bright_mode),
        .bright_code (bright_code),
        .level_flat  (level_flat),
        .led_on      (led_on)
    );

    function automatic int lvl(int seed, int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 256;
            3: return 511;
            default: return (seed * i + 13) % 512;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        // ---- table walk: frame-wide on-counts (R2, R3, R4, R5, R7, R8, R9)
        repeat (3) tick();
        rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            int cnt [CH];
            int span, frame, seed;
            @(negedge clk);
            out_en_n    = VEC[v][15];
            bright_mode = VEC[v][14];
            bright_code = VEC[v][13:11];
            seed        = int'(VEC[v][8:0]);
            for (int i = 0; i < CH; i++) level_flat[i*9 +: 9] = 9'(lvl(seed, i));
            span  = bright_mode ? int'(bright_code) + 9 : int'(bright_code) + 1;
            frame = 511 * (bright_mode ? 16 : 8);
            repeat (20) tick();
            for (int i = 0; i < CH; i++) cnt[i] = 0;
            for (int c = 0; c < frame; c++) begin
                tick();
                for (int i = 0; i < CH; i++) cnt[i] += int'(led_on[i]);
            end
            for (int i = 0; i < CH; i++)
                check(out_en_n ? "R5 forced off" :
                      (bright_mode ? "R4/R2/R7/R9 frame count" : "R3/R2/R7/R9 frame count"),
                      cnt[i], out_en_n ? 0 : lvl(seed, i) * span);
            if (v == 0) check("R8 full-on channel", cnt[3], frame);
        end

        // ---- directed: reset clears outputs (R1)
        @(negedge clk);
        out_en_n = 1'b0; bright_mode = 1'b0; bright_code = 3'd0;
        level_flat = '0;
        level_flat[8:0]  = 9'd1;
        level_flat[17:9] = 9'd2;
        for (int i = 2; i < CH; i++) level_flat[i*9 +: 9] = 9'h1FF;
        rst = 1'b1;
        tick();
        check("R1 reset dark", int'(led_on), 0);
        tick();
        @(negedge clk);
        rst = 1'b0;
        // ---- directed: cycle placement after release (R6, R3)
        tick();
        check("R6 edge1 ch0", int'(led_on[0]), 1);
        check("R6 edge1 ch1", int'(led_on[1]), 1);
        for (int e = 2; e <= 8; e++) begin
            tick();
            check("R3 tail of slot dark", int'(led_on[1:0]), 0);
        end
        tick();
        check("R6 slot1 ch0 (level 1)", int'(led_on[0]), 0);
        check("R6 slot1 ch1 (level 2)", int'(led_on[1]), 1);

        // ---- directed: output enable takes one edge (R5)
        @(negedge clk);
        bright_code = 3'd7;
        out_en_n = 1'b1;
        tick();
        check("R5 disable next edge", int'(led_on), 0);
        @(negedge clk);
        out_en_n = 1'b0;
        tick();
        check("R5 re-enable ch3", int'(led_on[3]), 1);

        // ---- directed: full-on stays high every cycle (R8)
        begin
            int lows = 0;
            for (int c = 0; c < 40; c++) begin
                tick();
                lows += int'(!led_on[3]);
            end
            check("R8 never low", lows, 0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule